// File: doc/BRIEF.md
# Protected Minute/Second Counter

This block keeps time as minutes and seconds, each held as a two-digit BCD byte. A one-cycle tick pulse, derived elsewhere from a low-speed clock at 1 Hz, advances the seconds. At 59 seconds the count wraps and carries into the minutes, and 59:59 rolls over to 00:00. Software reads the count continuously on `time_o`. Minutes sit in the upper byte and seconds in the lower byte.

Software writes through a small register port with byte enables. It can only change the time after writing a two-byte key to a guard register: first 0x3C, then 0xC3. That key grants a single write to the time register. A written field that is not legal BCD time loads 00:00 instead. A byte write of 00 into seconds while seconds reads 59 behaves like a rollover and carries into the minutes. A word write that loads both fields takes the written minutes as given.

A control bit enables a periodic interrupt pulse on each tick. Software can clear it so that the time can be set without raising a request. The time register has its own power-on reset. The general reset clears only the guard state, the interrupt enable and the interrupt output.

Top module: `rtc_min_sec`

## Requirements
- R1: `por_ni` low clears `time_o` to 0x0000 asynchronously. `rst_ni` alone never changes `time_o`.
- R2: Each `tick_i` pulse advances seconds in BCD from 0x00 to 0x59. From 0x59, seconds wrap to 0x00 and minutes advance, and minutes wrap from 0x59 to 0x00. The new value is visible after the clock edge that samples the tick.
- R3: Register map, selected by `addr_i` when `wr_i` is high: 0 is the guard register (data in `wdata_i[7:0]`), 1 is the time register, 2 is the control register. A time write takes effect only after guard writes of 0x3C and then 0xC3. Without them, a time write is ignored.
- R4: After 0x3C has been written, a guard write of any value other than 0x3C or 0xC3 discards it, and the sequence restarts. Writing 0x3C again keeps the block waiting for 0xC3.
- R5: While a time write is granted, a guard write of 0xC3 keeps the grant. Any other guard value, including 0x3C, revokes it without arming.
- R6: A grant permits exactly one time-register access, whether byte or word. A later access is ignored until the key is written again.
- R7: Byte enable `be_i[0]` writes seconds from `wdata_i[7:0]`, and `be_i[1]` writes minutes from `wdata_i[15:8]`. If any enabled byte has a tens digit above 5 or a units digit above 9, the whole time register loads 0x0000.
- R8: A seconds-only write of 0x00 while seconds hold 0x59 advances minutes by one, with minutes wrapping from 0x59 to 0x00.
- R9: A word write (`be_i` = 2'b11) of seconds 0x00 while seconds hold 0x59 loads the written minutes unchanged.
- R10: `rst_ni` low clears the guard state, any unused grant, the interrupt enable and `irq_o`.
- R11: Control bit `wdata_i[0]` at address 2 enables the interrupt. When it is enabled, `irq_o` is high for the one cycle after the edge that samples `tick_i`. When it is cleared, `irq_o` stays low.
- R12: If a granted time write and a tick arrive in the same cycle, the written value is stored and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low async reset for the guard, the enable and the interrupt |
| por_ni | input | 1 | Active-low async power-on reset for the time register |
| tick_i | input | 1 | One-cycle 1 Hz advance pulse |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 guard, 1 time, 2 control |
| be_i | input | 2 | Byte enables: bit 0 seconds, bit 1 minutes |
| wdata_i | input | 16 | Write data |
| time_o | output | 16 | {minutes BCD, seconds BCD} |
| irq_o | output | 1 | Periodic interrupt pulse |

## Verification
Every result is due one edge after its stimulus. A write or tick sampled at an edge shows on `time_o` right after that edge, and `irq_o` rises after the edge that samples the tick. The bench drives inputs just after the falling edge. A behavioural model updates at each rising edge, and the outputs are compared with it at every following falling edge. Directed checks of fixed expected times are sampled after the same edge, for the key sequences, range faults, carry cases and the write-versus-tick collision.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {UL_IDLE, UL_ARMED, UL_OPEN} unlock_e;

  localparam logic [1:0] ADDR_GUARD = 2'd0;
  localparam logic [1:0] ADDR_TIME  = 2'd1;
  localparam logic [1:0] ADDR_CTRL  = 2'd2;

  function automatic logic bcd_ok(input logic [7:0] v, input logic [3:0] max_tens);
    return (v[7:4] <= max_tens) && (v[3:0] <= 4'd9);
  endfunction

  function automatic logic [7:0] bcd_next(input logic [7:0] v, input logic [3:0] max_tens);
    if (v[3:0] == 4'd9) begin
      if (v[7:4] == max_tens) return 8'h00;
      return {4'(v[7:4] + 4'd1), 4'd0};
    end
    return {v[7:4], 4'(v[3:0] + 4'd1)};
  endfunction
endpackage

// File: rtl/rtc_unlock.sv
module rtc_unlock
  import rtc_pkg::*;
#(
  parameter logic [7:0] KEY_ARM  = 8'h3C,
  parameter logic [7:0] KEY_OPEN = 8'hC3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       guard_wr_i,
  input  logic [7:0] guard_data_i,
  input  logic       consume_i,
  output logic       grant_o
);
  unlock_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (guard_wr_i) begin
      unique case (st_q)
        UL_IDLE:  st_d = (guard_data_i == KEY_ARM) ? UL_ARMED : UL_IDLE;
        UL_ARMED: begin
          if (guard_data_i == KEY_OPEN)     st_d = UL_OPEN;
          else if (guard_data_i == KEY_ARM) st_d = UL_ARMED;
          else                              st_d = UL_IDLE;
        end
        UL_OPEN:  st_d = (guard_data_i == KEY_OPEN) ? UL_OPEN : UL_IDLE;
        default:  st_d = UL_IDLE;
      endcase
    end else if (consume_i && st_q == UL_OPEN) begin
      st_d = UL_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= UL_IDLE;
    else         st_q <= st_d;

  assign grant_o = (st_q == UL_OPEN);

  assert_key_opens_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == UL_ARMED && guard_wr_i && guard_data_i == KEY_OPEN) |=> grant_o);
  assert_bad_key_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (guard_wr_i && guard_data_i != KEY_ARM && guard_data_i != KEY_OPEN) |=> (st_q == UL_IDLE));
  assert_revoke_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && guard_wr_i && guard_data_i != KEY_OPEN) |=> !grant_o);
  assert_single_use_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && consume_i) |=> !grant_o);
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
#(
  parameter logic [3:0] MAX_TENS = 4'd5
) (
  input  logic        clk_i,
  input  logic        por_ni,
  input  logic        tick_i,
  input  logic        wr_i,
  input  logic [1:0]  be_i,
  input  logic [15:0] wdata_i,
  output logic [7:0]  sec_o,
  output logic [7:0]  min_o
);
  localparam logic [7:0] TOP = {MAX_TENS, 4'd9};

  logic [7:0] sec_q, min_q, sec_d, min_d;
  logic [7:0] w_sec, w_min;
  logic       sec_bad, min_bad;

  assign w_sec   = wdata_i[7:0];
  assign w_min   = wdata_i[15:8];
  assign sec_bad = be_i[0] && !bcd_ok(w_sec, MAX_TENS);
  assign min_bad = be_i[1] && !bcd_ok(w_min, MAX_TENS);

  always_comb begin
    sec_d = sec_q;
    min_d = min_q;
    if (wr_i) begin
      if (sec_bad || min_bad) begin
        sec_d = 8'h00;
        min_d = 8'h00;
      end else begin
        if (be_i[0]) sec_d = w_sec;
        if (be_i[1]) min_d = w_min;
        else if (be_i[0] && sec_q == TOP && w_sec == 8'h00)
          min_d = bcd_next(min_q, MAX_TENS);
      end
    end else if (tick_i) begin
      sec_d = bcd_next(sec_q, MAX_TENS);
      if (sec_q == TOP) min_d = bcd_next(min_q, MAX_TENS);
    end
  end

  always_ff @(posedge clk_i or negedge por_ni)
    if (!por_ni) begin
      sec_q <= 8'h00;
      min_q <= 8'h00;
    end else begin
      sec_q <= sec_d;
      min_q <= min_d;
    end

  assign sec_o = sec_q;
  assign min_o = min_q;

  assert_time_legal_R7: assert property (@(posedge clk_i) disable iff (!por_ni)
    bcd_ok(sec_q, MAX_TENS) && bcd_ok(min_q, MAX_TENS));
  assert_tick_carry_R2: assert property (@(posedge clk_i) disable iff (!por_ni)
    (tick_i && !wr_i && sec_q == TOP && min_q != TOP) |=> (sec_q == 8'h00 && min_q != $past(min_q)));
  assert_byte_carry_R8: assert property (@(posedge clk_i) disable iff (!por_ni)
    (wr_i && be_i == 2'b01 && sec_q == TOP && w_sec == 8'h00 && min_q != TOP)
      |=> (min_q != $past(min_q)));
  assert_word_no_carry_R9: assert property (@(posedge clk_i) disable iff (!por_ni)
    (wr_i && be_i == 2'b11 && !sec_bad && !min_bad) |=> (min_q == $past(w_min)));
endmodule

// File: rtl/rtc_irq_gen.sv
module rtc_irq_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_wr_i,
  input  logic ctrl_bit_i,
  input  logic tick_i,
  output logic irq_o
);
  logic en_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= tick_i && en_q;
      if (ctrl_wr_i) en_q <= ctrl_bit_i;
    end

  assign irq_o = irq_q;

  assert_irq_from_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(tick_i));
endmodule

// File: rtl/rtc_min_sec.sv
module rtc_min_sec
  import rtc_pkg::*;
#(
  parameter logic [7:0] KEY_ARM  = 8'h3C,
  parameter logic [7:0] KEY_OPEN = 8'hC3,
  parameter logic [3:0] MAX_TENS = 4'd5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        por_ni,
  input  logic        tick_i,
  input  logic        wr_i,
  input  logic [1:0]  addr_i,
  input  logic [1:0]  be_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] time_o,
  output logic        irq_o
);
  logic guard_wr, time_wr, ctrl_wr, grant;
  logic [7:0] sec, min;

  assign guard_wr = wr_i && addr_i == ADDR_GUARD;
  assign time_wr  = wr_i && addr_i == ADDR_TIME;
  assign ctrl_wr  = wr_i && addr_i == ADDR_CTRL;

  rtc_unlock #(.KEY_ARM(KEY_ARM), .KEY_OPEN(KEY_OPEN)) u_unlock (
    .clk_i(clk_i), .rst_ni(rst_ni), .guard_wr_i(guard_wr),
    .guard_data_i(wdata_i[7:0]), .consume_i(time_wr), .grant_o(grant)
  );

  rtc_time_core #(.MAX_TENS(MAX_TENS)) u_core (
    .clk_i(clk_i), .por_ni(por_ni), .tick_i(tick_i), .wr_i(time_wr && grant),
    .be_i(be_i), .wdata_i(wdata_i), .sec_o(sec), .min_o(min)
  );

  rtc_irq_gen u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_wr_i(ctrl_wr),
    .ctrl_bit_i(wdata_i[0]), .tick_i(tick_i), .irq_o(irq_o)
  );

  assign time_o = {min, sec};

  assert_ungranted_ignored_R3: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (time_wr && !grant && !tick_i) |=> $stable(time_o));
endmodule

// File: tb/tb_rtc_min_sec.sv
module tb_rtc_min_sec;
  logic clk = 0, rst_n = 0, por_n = 0, tick = 0, wr = 0;
  logic [1:0] addr = 0, be = 0;
  logic [15:0] wdata = 0;
  logic [15:0] time_o;
  logic irq_o;
  int checks = 0, errors = 0;
  bit live = 0, done = 0;
  string phase = "R1";

  int m_min = 0, m_sec = 0, m_st = 0;
  bit m_en = 0, m_irq = 0;

  always #2 clk = ~clk;

  rtc_min_sec dut (.clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .tick_i(tick),
    .wr_i(wr), .addr_i(addr), .be_i(be), .wdata_i(wdata), .time_o(time_o), .irq_o(irq_o));

  function automatic bit legal(input logic [7:0] b);
    return (b[7:4] <= 5) && (b[3:0] <= 9);
  endfunction
  function automatic int dec(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [15:0] enc(input int mn, input int sc);
    return {4'(mn / 10), 4'(mn % 10), 4'(sc / 10), 4'(sc % 10)};
  endfunction

  // behavioural reference
  always @(posedge clk) begin
    if (!por_n) begin m_min = 0; m_sec = 0; end
    else if (wr && addr == 1 && m_st == 2) begin
      if ((be[0] && !legal(wdata[7:0])) || (be[1] && !legal(wdata[15:8]))) begin
        m_min = 0; m_sec = 0;
      end else begin
        int old_sec;
        old_sec = m_sec;
        if (be[0]) m_sec = dec(wdata[7:0]);
        if (be[1]) m_min = dec(wdata[15:8]);
        else if (be[0] && old_sec == 59 && m_sec == 0) m_min = (m_min + 1) % 60;
      end
    end else if (tick) begin
      if (m_sec == 59) begin m_sec = 0; m_min = (m_min + 1) % 60; end
      else m_sec++;
    end
    if (!rst_n) begin m_st = 0; m_en = 0; m_irq = 0; end
    else begin
      m_irq = tick && m_en;
      if (wr && addr == 0) begin
        case (m_st)
          0: m_st = (wdata[7:0] == 8'h3C) ? 1 : 0;
          1: m_st = (wdata[7:0] == 8'hC3) ? 2 : (wdata[7:0] == 8'h3C) ? 1 : 0;
          default: m_st = (wdata[7:0] == 8'hC3) ? 2 : 0;
        endcase
      end else if (wr && addr == 1 && m_st == 2) m_st = 0;
      if (wr && addr == 2) m_en = wdata[0];
    end
  end

  always @(negedge clk) if (live && !done) begin
    checks++;
    if (time_o !== enc(m_min, m_sec)) begin
      errors++;
      $display("FAIL %s model time act=%h exp=%h", phase, time_o, enc(m_min, m_sec));
    end
    checks++;
    if (irq_o !== m_irq) begin
      errors++;
      $display("FAIL %s model irq act=%b exp=%b", phase, irq_o, m_irq);
    end
  end

  task automatic step(); @(negedge clk); #1; endtask
  task automatic bus(input logic [1:0] a, input logic [15:0] d, input logic [1:0] b);
    wr = 1; addr = a; wdata = d; be = b; step(); wr = 0; be = 0;
  endtask
  task automatic key(); bus(0, 16'h3C, 2'b01); bus(0, 16'hC3, 2'b01); endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tick = 1; step(); tick = 0; end
  endtask
  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step(); step();
    chk("R1", time_o, 16'h0000);
    chk("R1", {15'd0, irq_o}, 16'h0000);
    live = 1;
    rst_n = 1; por_n = 1; step();

    phase = "R2"; bus(2, 16'h1, 2'b01); ticks(65);
    chk("R2", time_o, 16'h0105);
    phase = "R11"; tick = 1; step(); tick = 0;
    chk("R11", {15'd0, irq_o}, 16'h0001); step();
    chk("R11", {15'd0, irq_o}, 16'h0000);

    phase = "R3"; bus(1, 16'h0030, 2'b01);
    chk("R3", time_o, 16'h0106);
    key(); bus(1, 16'h1234, 2'b11);
    chk("R3", time_o, 16'h1234);

    phase = "R6"; key(); bus(1, 16'h0020, 2'b01); bus(1, 16'h0011, 2'b01);
    chk("R6", time_o, 16'h1220);

    phase = "R4"; bus(0, 16'h3C, 2'b01); bus(0, 16'h55, 2'b01); bus(0, 16'hC3, 2'b01);
    bus(1, 16'h0001, 2'b01);
    chk("R4", time_o, 16'h1220);
    bus(0, 16'h3C, 2'b01); bus(0, 16'h3C, 2'b01); bus(0, 16'hC3, 2'b01);
    bus(1, 16'h0002, 2'b01);
    chk("R4", time_o, 16'h1202);

    phase = "R5"; key(); bus(0, 16'hC3, 2'b01); bus(1, 16'h0500, 2'b10);
    chk("R5", time_o, 16'h0502);
    key(); bus(0, 16'h3C, 2'b01); bus(1, 16'h0700, 2'b10);
    chk("R5", time_o, 16'h0502);
    bus(0, 16'hC3, 2'b01); bus(1, 16'h0700, 2'b10);
    chk("R5", time_o, 16'h0502);

    phase = "R7"; key(); bus(1, 16'h6010, 2'b11);
    chk("R7", time_o, 16'h0000);
    key(); bus(1, 16'h2233, 2'b11); key(); bus(1, 16'h000A, 2'b01);
    chk("R7", time_o, 16'h0000);
    key(); bus(1, 16'h4444, 2'b11); key(); bus(1, 16'h5A00, 2'b10);
    chk("R7", time_o, 16'h0000);

    phase = "R8"; key(); bus(1, 16'h1759, 2'b11); key(); bus(1, 16'h0000, 2'b01);
    chk("R8", time_o, 16'h1800);
    key(); bus(1, 16'h5959, 2'b11); key(); bus(1, 16'h0000, 2'b01);
    chk("R8", time_o, 16'h0000);

    phase = "R9"; key(); bus(1, 16'h1759, 2'b11); key(); bus(1, 16'h4000, 2'b11);
    chk("R9", time_o, 16'h4000);

    phase = "R2"; key(); bus(1, 16'h5958, 2'b11); ticks(2);
    chk("R2", time_o, 16'h0000);

    phase = "R12"; key(); bus(1, 16'h2010, 2'b11);
    key(); tick = 1; bus(1, 16'h0030, 2'b01); tick = 0;
    chk("R12", time_o, 16'h2030);

    phase = "R10"; key(); rst_n = 0; step(); step(); rst_n = 1; step();
    chk("R1", time_o, 16'h2030);
    bus(1, 16'h0005, 2'b01);
    chk("R10", time_o, 16'h2030);
    ticks(1);
    chk("R10", {15'd0, irq_o}, 16'h0000);

    phase = "R11"; bus(2, 16'h1, 2'b01); bus(2, 16'h0, 2'b01); ticks(3);
    chk("R11", {15'd0, irq_o}, 16'h0000);
    chk("R11", time_o, 16'h2034);

    phase = "R1"; por_n = 0; step();
    chk("R1", time_o, 16'h0000);
    por_n = 1; step();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule